// File: doc/BRIEF.md
# Dual-Channel Hot-Swap Switch Controller

This block is the digital control core of a two-channel hot-swap power switch. Each channel watches four synchronized inputs: an active-low enable that says a board is seated, an on request pin, an overvoltage comparator and a power-good comparator. From these it keeps an on bit, a three-bit fault register and a channel state (off, ramping, up). While a channel ramps or is up, its gate-enable output is high. A fixed-length timer stands in for the turn-on sequence. When that timer expires, startup is done.

A mode input picks ganged or independent control. In ganged mode the two channels start, and stop, as one. In independent mode each channel runs alone, but two turn-on sequences never overlap. A small write port lets the host set the on bits, the alert mask and either fault register. The block also provides a registered power-good indicator and an active-low alert.

Top module: `hsw_ctrl`

## Requirements
- R1: During and right after reset, `gate`, `start_done`, `pwr_good` and `faults` are all zero and `alert_n` is one.
- R2: After reset, the power-up delay runs for PWRUP_CYC clocks. On the edge that ends it, each on bit is loaded from its `on_req` pin, so a channel whose pin is high turns its gate on one edge later. A channel whose pin is low stays off. Pin edges seen before the delay ends are ignored.
- R3: A channel's gate rises one edge after its run condition holds. Its `start_done` rises RAMP_CYC edges after the gate rises, and that sets the end of startup.
- R4: In independent mode (`indep`=1) only one channel ramps at a time. A channel requested while the other ramps waits until the other is up. When both channels are requested in the same cycle, channel 0 goes first.
- R5: In ganged mode (`indep`=0) the gates open only when both channels can run, and they ramp together. A fault, a high enable or an off command on either channel turns both gates off. The mode is changed only while both gates are off.
- R6: While `en_n[i]` is high, gate i stays off. Every enable transition after power-up sets fault bit 2 of that channel.
- R7: A falling edge on `en_n[i]` clears the channel's fault register, then sets bit 2. It also loads the on bit from the present `on_req[i]` level.
- R8: A rising edge on `on_req[i]` sets the on bit. A falling edge clears the on bit and clears the channel's fault register.
- R9: A high `ov_hi[i]` sets fault bit 0 and turns gate i off on the same edge. The other channel is not affected in independent mode.
- R10: Fault bit 1 (power bad) is set only when `fb_ok[i]` is low while the channel is up. A low `fb_ok` during the ramp sets nothing.
- R11: `pwr_good[i]` is high one edge after `fb_ok[i]` is high while the channel is up, and low otherwise.
- R12: `alert_n` goes low one edge after any fault bit whose mask bit is set. A fault with its mask bit clear leaves `alert_n` high.
- R13: A set fault bit 0 or bit 1 holds the gate off until the fault is cleared. The host write port behaves as follows when `wr_en` is high:
  - address 0 loads on bit i from `wr_data[i]`;
  - address 1 loads the mask, which has the same layout as `faults`;
  - address 2 loads channel 0 faults from `wr_data[2:0]`;
  - address 3 loads channel 1 faults from `wr_data[2:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| indep | input | 1 | 1 = independent channels, 0 = ganged |
| en_n | input | 2 | Per-channel active-low enable |
| on_req | input | 2 | Per-channel on request pin |
| ov_hi | input | 2 | Per-channel overvoltage comparator, high = over |
| fb_ok | input | 2 | Per-channel power-good comparator, high = good |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Host write address |
| wr_data | input | 6 | Host write data |
| gate | output | 2 | Per-channel gate enable |
| start_done | output | 2 | Per-channel startup finished |
| pwr_good | output | 2 | Per-channel registered power good |
| faults | output | 6 | Fault registers: [2:0] channel 0, [5:3] channel 1; bit 0 overvoltage, bit 1 power bad, bit 2 enable transition |
| alert_n | output | 1 | Active-low alert |

## Verification
The hardest state to reach is a request that waits on the other channel's ramp. This covers a simultaneous request for both channels in independent mode, and a second channel asked for while the first is still mid-ramp. The stimulus table raises both on pins in one cycle and then counts edges across both ramp windows. It checks that channel 1 opens exactly one edge after channel 0 reports done. Power bad while ramping is reached by holding the feedback low through a restart, so only the transition to up can log it.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
  timeunit 1ns; timeprecision 1ps;
  localparam int NCH   = 2;
  localparam int FLT_W = 3;
  localparam int F_OV  = 0;
  localparam int F_PB  = 1;
  localparam int F_EN  = 2;
  localparam logic [1:0] A_ON   = 2'd0;
  localparam logic [1:0] A_MASK = 2'd1;
  localparam logic [1:0] A_FLT0 = 2'd2;
  localparam logic [1:0] A_FLT1 = 2'd3;
  typedef enum logic [1:0] {CH_OFF = 2'd0, CH_RAMP = 2'd1, CH_UP = 2'd2} ch_state_e;
endpackage

// File: rtl/hsw_chan.sv
module hsw_chan
  import hsw_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             armed,
  input  logic             pu_fire,
  input  logic             en_n,
  input  logic             on_req,
  input  logic             ov_hi,
  input  logic             fb_ok,
  input  logic             is_up,
  input  logic             wr_on,
  input  logic             wr_on_val,
  input  logic             wr_flt,
  input  logic [FLT_W-1:0] wr_flt_val,
  output logic             on_bit,
  output logic [FLT_W-1:0] flt,
  output logic             run
);
  timeunit 1ns; timeprecision 1ps;

  logic en_q, on_q;
  logic en_fall, en_rise, on_rise, on_fall;
  logic [FLT_W-1:0] flt_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b1;
      on_q <= 1'b0;
    end else begin
      en_q <= en_n;
      on_q <= on_req;
    end
  end

  assign en_fall = armed & en_q & ~en_n;
  assign en_rise = armed & ~en_q & en_n;
  assign on_rise = armed & ~on_q & on_req;
  assign on_fall = armed & on_q & ~on_req;

  always_ff @(posedge clk) begin
    if (rst)          on_bit <= 1'b0;
    else if (pu_fire) on_bit <= on_req;
    else if (en_fall) on_bit <= on_req;
    else if (on_rise) on_bit <= 1'b1;
    else if (on_fall) on_bit <= 1'b0;
    else if (wr_on)   on_bit <= wr_on_val;
  end

  always_comb begin
    flt_nxt = flt;
    if (en_fall | on_fall) flt_nxt = '0;
    else if (wr_flt)       flt_nxt = wr_flt_val;
    flt_nxt[F_OV] = flt_nxt[F_OV] | ov_hi;
    flt_nxt[F_PB] = flt_nxt[F_PB] | (is_up & ~fb_ok);
    flt_nxt[F_EN] = flt_nxt[F_EN] | en_fall | en_rise;
  end

  always_ff @(posedge clk) begin
    if (rst) flt <= '0;
    else     flt <= flt_nxt;
  end

  // Gate may run only with the on bit, enable low, no overvoltage, no latched trip.
  assign run = on_bit & ~en_n & ~ov_hi & ~flt[F_OV] & ~flt[F_PB];

  // R9: overvoltage is always logged
  a_r9_ov_logged: assert property (@(posedge clk) disable iff (rst)
    ov_hi |=> flt[F_OV]);

  // R6: enable rising after power-up is recorded
  a_r6_en_rise_logged: assert property (@(posedge clk) disable iff (rst)
    (armed && $rose(en_n)) |=> flt[F_EN]);

  // R8: an on-pin falling edge clears the trip bits when nothing re-trips
  a_r8_fall_clears: assert property (@(posedge clk) disable iff (rst)
    (armed && $fell(on_req) && fb_ok && !ov_hi) |=> (!flt[F_OV] && !flt[F_PB]));
endmodule

// File: rtl/hsw_seq.sv
module hsw_seq
  import hsw_pkg::*;
#(
  parameter int RAMP_CYC = 1000
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           indep,
  input  logic [NCH-1:0] run,
  output logic [NCH-1:0] gate,
  output logic [NCH-1:0] done
);
  timeunit 1ns; timeprecision 1ps;

  localparam int CW = $clog2(RAMP_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(RAMP_CYC - 1);

  ch_state_e      st_q  [NCH];
  logic [CW-1:0]  cnt_q [NCH];
  logic [NCH-1:0] want, grant;

  assign want     = indep ? run : {NCH{&run}};
  // Channel 0 wins a tie; each waits while the other ramps.
  assign grant[0] = ~indep | (st_q[1] != CH_RAMP);
  assign grant[1] = ~indep | ((st_q[0] != CH_RAMP) & ~((st_q[0] == CH_OFF) & want[0]));

  always_ff @(posedge clk) begin
    for (int i = 0; i < NCH; i++) begin
      if (rst || !want[i]) begin
        st_q[i]  <= CH_OFF;
        cnt_q[i] <= '0;
      end else begin
        case (st_q[i])
          CH_OFF: if (grant[i]) begin
            st_q[i]  <= CH_RAMP;
            cnt_q[i] <= '0;
          end
          CH_RAMP: if (cnt_q[i] == LAST) st_q[i] <= CH_UP;
                   else cnt_q[i] <= cnt_q[i] + 1'b1;
          default: st_q[i] <= CH_UP;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign gate[g] = (st_q[g] != CH_OFF);
    assign done[g] = (st_q[g] == CH_UP);

    // R6: a gate is open only if the channel wanted to run on the prior edge
    a_r6_gate_needs_want: assert property (@(posedge clk) disable iff (rst)
      gate[g] |-> $past(want[g]));
  end

  // R4: independent ramps never overlap
  a_r4_single_ramp: assert property (@(posedge clk) disable iff (rst)
    indep |-> !((st_q[0] == CH_RAMP) && (st_q[1] == CH_RAMP)));

  // R5: ganged gates move together
  a_r5_ganged_match: assert property (@(posedge clk) disable iff (rst)
    !indep |-> (gate[0] == gate[1]));
endmodule

// File: rtl/hsw_ctrl.sv
module hsw_ctrl
  import hsw_pkg::*;
#(
  parameter int PWRUP_CYC = 5000000,
  parameter int RAMP_CYC  = 1000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               indep,
  input  logic [NCH-1:0]     en_n,
  input  logic [NCH-1:0]     on_req,
  input  logic [NCH-1:0]     ov_hi,
  input  logic [NCH-1:0]     fb_ok,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [NCH*FLT_W-1:0] wr_data,
  output logic [NCH-1:0]     gate,
  output logic [NCH-1:0]     start_done,
  output logic [NCH-1:0]     pwr_good,
  output logic [NCH*FLT_W-1:0] faults,
  output logic               alert_n
);
  timeunit 1ns; timeprecision 1ps;

  localparam int PW = $clog2(PWRUP_CYC + 1);
  localparam logic [PW-1:0] PU_LAST = PW'(PWRUP_CYC - 1);

  logic [PW-1:0]          pu_cnt;
  logic                   pu_done, pu_fire;
  logic [NCH*FLT_W-1:0]   mask_q;
  logic [NCH-1:0]         run_w;

  assign pu_fire = ~pu_done & (pu_cnt == PU_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pu_cnt  <= '0;
      pu_done <= 1'b0;
    end else if (!pu_done) begin
      if (pu_fire) pu_done <= 1'b1;
      else         pu_cnt  <= pu_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                              mask_q <= '0;
    else if (wr_en && wr_addr == A_MASK)  mask_q <= wr_data;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    hsw_chan u_chan (
      .clk        (clk),
      .rst        (rst),
      .armed      (pu_done),
      .pu_fire    (pu_fire),
      .en_n       (en_n[g]),
      .on_req     (on_req[g]),
      .ov_hi      (ov_hi[g]),
      .fb_ok      (fb_ok[g]),
      .is_up      (start_done[g]),
      .wr_on      (wr_en && wr_addr == A_ON),
      .wr_on_val  (wr_data[g]),
      .wr_flt     (wr_en && wr_addr == ((g == 0) ? A_FLT0 : A_FLT1)),
      .wr_flt_val (wr_data[FLT_W-1:0]),
      .on_bit     (),
      .flt        (faults[g*FLT_W +: FLT_W]),
      .run        (run_w[g])
    );
  end

  hsw_seq #(.RAMP_CYC(RAMP_CYC)) u_seq (
    .clk   (clk),
    .rst   (rst),
    .indep (indep),
    .run   (run_w),
    .gate  (gate),
    .done  (start_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      alert_n  <= 1'b1;
      pwr_good <= '0;
    end else begin
      alert_n  <= ~|(faults & mask_q);
      pwr_good <= fb_ok & start_done;
    end
  end

  // R12: an enabled fault pulls the alert low on the next edge
  a_r12_alert_on: assert property (@(posedge clk) disable iff (rst)
    (|(faults & mask_q)) |=> !alert_n);

  // R12: no enabled fault, no alert
  a_r12_alert_off: assert property (@(posedge clk) disable iff (rst)
    !(|(faults & mask_q)) |=> alert_n);

  // R11: power good follows a good comparator only
  a_r11_pg_source: assert property (@(posedge clk) disable iff (rst)
    pwr_good[0] |-> $past(fb_ok[0]));
endmodule

// File: tb/hsw_ctrl_test.sv
module hsw_ctrl_test;
  timeunit 1ns; timeprecision 1ps;

  localparam int P = 6;
  localparam int R = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       indep = 1'b1;
  logic [1:0] en_n = 2'b00, on_req = 2'b01, ov_hi = 2'b00, fb_ok = 2'b11;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [5:0] wr_data = '0;
  logic [1:0] gate, start_done, pwr_good;
  logic [5:0] faults;
  logic       alert_n;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  hsw_ctrl #(.PWRUP_CYC(P), .RAMP_CYC(R)) uut (
    .clk(clk), .rst(rst), .indep(indep), .en_n(en_n), .on_req(on_req),
    .ov_hi(ov_hi), .fb_ok(fb_ok), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .gate(gate), .start_done(start_done),
    .pwr_good(pwr_good), .faults(faults), .alert_n(alert_n)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      failures = failures + 1;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 5000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  typedef struct packed {
    logic [1:0] en_n;
    logic [1:0] on;
    logic [1:0] ov;
    logic [1:0] fb;
    logic [7:0] wt;
    logic [1:0] eg;
    logic [1:0] ed;
  } vec_t;

  // Independent-mode sequence, starting with channel 0 up and channel 1 off.
  localparam vec_t VEC [10] = '{
    '{2'b00, 2'b11, 2'b00, 2'b11, 8'd2,     2'b11, 2'b01}, // R3 ch1 on
    '{2'b00, 2'b11, 2'b00, 2'b11, 8'(R),    2'b11, 2'b11}, // R3 ch1 done
    '{2'b00, 2'b01, 2'b00, 2'b11, 8'd2,     2'b01, 2'b01}, // R8 ch1 off, R9-style isolation
    '{2'b00, 2'b00, 2'b00, 2'b11, 8'd2,     2'b00, 2'b00}, // R8 ch0 off
    '{2'b00, 2'b11, 2'b00, 2'b11, 8'd2,     2'b01, 2'b00}, // R4 tie, ch0 first
    '{2'b00, 2'b11, 2'b00, 2'b11, 8'(R),    2'b01, 2'b01}, // R4 ch1 still waiting
    '{2'b00, 2'b11, 2'b00, 2'b11, 8'd1,     2'b11, 2'b01}, // R4 ch1 starts after ch0 up
    '{2'b00, 2'b11, 2'b00, 2'b11, 8'(R),    2'b11, 2'b11}, // R4 both up
    '{2'b10, 2'b11, 2'b00, 2'b11, 8'd2,     2'b01, 2'b01}, // R6 enable high blocks ch1
    '{2'b00, 2'b11, 2'b00, 2'b11, 8'd1,     2'b11, 2'b01}  // R7 enable fall restarts ch1
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [5:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  initial begin
    step(3);
    chk("R1 gate", 8'(gate), 8'h0);
    chk("R1 faults", 8'(faults), 8'h0);
    chk("R1 alert_n", 8'(alert_n), 8'h1);
    chk("R1 done", 8'(start_done), 8'h0);
    rst = 1'b0;
    step(1);
    chk("R1 pg after reset", 8'(pwr_good), 8'h0);
    step(P - 1);
    chk("R2 gate before delay", 8'(gate), 8'h0);
    step(1);
    chk("R2 ch0 on, ch1 off", 8'(gate), 8'h1);
    step(R - 1);
    chk("R3 not yet done", 8'(start_done), 8'h0);
    step(1);
    chk("R3 done", 8'(start_done), 8'h1);
    step(1);
    chk("R11 pg", 8'(pwr_good), 8'h1);

    on_req = 2'b11;
    foreach (VEC[k]) begin
      en_n = VEC[k].en_n; on_req = VEC[k].on; ov_hi = VEC[k].ov; fb_ok = VEC[k].fb;
      step(int'(VEC[k].wt));
      chk($sformatf("R3/R4/R6/R8 vec%0d gate", k), 8'(gate), 8'(VEC[k].eg));
      chk($sformatf("R3/R4/R6/R8 vec%0d done", k), 8'(start_done), 8'(VEC[k].ed));
    end

    step(R);
    chk("R7 done both", 8'(start_done), 8'h3);
    chk("R7 ch1 en bit only", 8'(faults), 8'h20);
    host_wr(2'd3, 6'd0);
    chk("R13 fault write", 8'(faults), 8'h00);
    host_wr(2'd1, 6'h3F);
    step(1);
    chk("R12 no fault no alert", 8'(alert_n), 8'h1);

    ov_hi = 2'b10;
    step(1);
    chk("R9 ov logged", 8'(faults), 8'h08);
    chk("R9 ch1 gate off only", 8'(gate), 8'h1);
    step(1);
    chk("R12 alert", 8'(alert_n), 8'h0);
    ov_hi = 2'b00;
    step(2);
    chk("R13 trip holds gate", 8'(gate), 8'h1);
    on_req = 2'b01;
    step(1);
    chk("R8 fall clears", 8'(faults), 8'h00);
    step(1);
    chk("R12 alert release", 8'(alert_n), 8'h1);

    host_wr(2'd1, 6'h00);
    host_wr(2'd2, 6'h01);
    chk("R13 write ch0 fault", 8'(faults), 8'h01);
    step(2);
    chk("R12 masked no alert", 8'(alert_n), 8'h1);
    chk("R13 written trip gates off", 8'(gate), 8'h0);

    fb_ok = 2'b10;
    step(1);
    chk("R10 no pb while off", 8'(faults), 8'h01);
    host_wr(2'd2, 6'h00);
    step(2);
    chk("R10 ramp gate", 8'(gate), 8'h1);
    chk("R10 no pb in ramp", 8'(faults), 8'h00);
    step(R);
    chk("R10 pb when up", 8'(faults), 8'h02);
    chk("R11 pg low", 8'(pwr_good), 8'h0);
    step(1);
    chk("R10 pb gate off", 8'(gate), 8'h0);

    on_req = 2'b00; fb_ok = 2'b11;
    step(3);
    chk("R5 prep off", 8'(gate), 8'h0);
    indep = 1'b0;
    on_req = 2'b01;
    step(3);
    chk("R5 needs both", 8'(gate), 8'h0);
    on_req = 2'b11;
    step(2);
    chk("R5 open together", 8'(gate), 8'h3);
    step(R);
    chk("R5 done together", 8'(start_done), 8'h3);
    en_n = 2'b01;
    step(2);
    chk("R5 both off", 8'(gate), 8'h0);
    chk("R6 en bit ch0", 8'(faults), 8'h04);
    host_wr(2'd0, 6'b000010);
    en_n = 2'b00;
    step(2);
    chk("R7 on sampled", 8'(gate), 8'h3);
    chk("R7 cleared then recorded", 8'(faults), 8'h04);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule